// File: doc/BRIEF.md
# Double-Buffered PWM Bank with Memory-Fed Duty Values

This block drives a bank of pulse-width outputs that all share one period counter. Each channel has an active compare value and a shadow value. The block fetches a fresh set of duty values from memory through a small read-request port. Each 32-bit word it reads carries the compare values for a pair of channels, so half as many reads as channels refill the whole shadow set.

A fetch starts as soon as a new set has been copied into the active registers, which leaves the memory side a whole period to answer. At each period boundary the active set is replaced, but only if every word of the shadow set has already returned. If any word is still missing, the whole previous set plays again, a sticky flag records the late update, and the completed set takes effect at the next boundary. Outputs therefore never switch mid-period and never mix old and new duties. The period and the base address are plain inputs. With a single-cycle memory response, a set of W words completes in W cycles, so per-period updates are possible down to very short periods.

Top module: `pwm_dma_shadow`

## Requirements
- R1: The period counter runs 0, 1, ..., period-1 and wraps to 0. Output i is high exactly while the counter is below active compare i: a compare of 0 keeps it low, and a compare at or above the period keeps it high for the whole period.
- R2: Word k of a set is read from base_addr + 4*k for k = 0 up to CH/2-1, in ascending order. Bits [15:0] of word k go to channel 2k and bits [31:16] go to channel 2k+1. At most one read is outstanding, and the next request follows the response to the previous one.
- R3: Active compare values change only at a period boundary, so a channel's duty within any one period comes from a single set.
- R4: In the first cycle after a set is loaded (and in the first cycle after reset), the request for word 0 of the next set is presented.
- R5: If the last word of a set has not been accepted at a clock edge strictly before the boundary edge, the whole previous active set is used again for the next period. This includes the case where the last word arrives on the boundary edge itself. No partially fetched value is used.
- R6: A set that completes late is loaded at the first boundary after it completes, and the next fetch then starts as in R4.
- R7: late_flag rises at the boundary where a set is replayed. It stays high until reset.
- R8: During and right after reset, all outputs are low, all active compares are zero, late_flag is low, and a request for word 0 at base_addr is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_addr | input | AW | Byte address of word 0 of the duty set |
| period | input | CW | Period length in clock cycles |
| rd_req | output | 1 | Read request, accepted in the cycle it is high |
| rd_addr | output | AW | Byte address of the requested word |
| rd_rvalid | input | 1 | Read data valid |
| rd_rdata | input | 2*CW | Read data, two compare values |
| pwm_out | output | CH | One PWM output per channel |
| late_flag | output | 1 | Sticky flag: a period replayed stale duty values |

## Verification
The bench targets the edges of the compare range, the tie where the last word lands on the boundary edge itself, and fetches that straddle a boundary. A design that compared with the wrong operator would stretch or drop one cycle on zero and full-scale duties. A design that latched complete data on the boundary edge would load when it must replay. A design that copied words as they arrived would leave some channels on new duties while the others stayed on old ones. Address order and the restart of the fetch after each load are also checked, since a swapped half-word or a skipped restart would feed channels the wrong duty or stall every later update.

// File: rtl/pwm_dma_shadow.sv
module pwm_dma_shadow #(
  parameter int CH = 12,
  parameter int CW = 16,
  parameter int AW = 32
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   base_addr,
  input  logic [CW-1:0]   period,
  output logic            rd_req,
  output logic [AW-1:0]   rd_addr,
  input  logic            rd_rvalid,
  input  logic [2*CW-1:0] rd_rdata,
  output logic [CH-1:0]   pwm_out,
  output logic            late_flag
);
  localparam int WORDS = CH / 2;
  localparam int IW = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [IW-1:0] LAST = IW'(WORDS - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] act [CH];
  logic [CW-1:0] shd [CH];
  logic [IW-1:0] idx;
  logic          busy, wait_rsp, full;
  logic          boundary, load;

  assign boundary = ({1'b0, cnt} + {{CW{1'b0}}, 1'b1}) >= {1'b0, period};
  assign load     = boundary & full;
  assign rd_req   = busy & ~wait_rsp;
  assign rd_addr  = base_addr + AW'({idx, 2'b00});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      idx       <= '0;
      busy      <= 1'b1;
      wait_rsp  <= 1'b0;
      full      <= 1'b0;
      late_flag <= 1'b0;
      for (int i = 0; i < CH; i++) begin
        act[i] <= '0;
        shd[i] <= '0;
      end
    end else begin
      cnt <= boundary ? '0 : cnt + 1'b1;
      if (rd_req) wait_rsp <= 1'b1;
      if (rd_rvalid && busy) begin
        for (int k = 0; k < WORDS; k++)
          if (idx == IW'(k)) begin
            shd[2*k]   <= rd_rdata[CW-1:0];
            shd[2*k+1] <= rd_rdata[2*CW-1:CW];
          end
        wait_rsp <= 1'b0;
        if (idx == LAST) begin
          busy <= 1'b0;
          full <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
      if (boundary) begin
        if (full) begin
          for (int i = 0; i < CH; i++) act[i] <= shd[i];
          full     <= 1'b0;
          busy     <= 1'b1;
          idx      <= '0;
          wait_rsp <= 1'b0;
        end else begin
          late_flag <= 1'b1;
        end
      end
    end
  end

  for (genvar i = 0; i < CH; i++) begin : g_out
    assign pwm_out[i] = cnt < act[i];
  end
endmodule

// File: rtl/pwm_dma_shadow_chk.sv
module pwm_dma_shadow_chk #(
  parameter int CH = 12,
  parameter int CW = 16
)(
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] period,
  input logic [CW-1:0] cnt,
  input logic [CH-1:0] pwm_out,
  input logic          late_flag,
  input logic          rd_req,
  input logic          rd_rvalid,
  input logic          load
);
  assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (period != '0 && $stable(period) && $past(cnt) < period) |-> cnt < period);

  assert_one_outstanding_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_rvalid) |=> !rd_req);

  assert_rise_at_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pwm_out & ~$past(pwm_out))) |-> cnt == '0);

  assert_prefetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> rd_req);

  assert_late_at_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(late_flag) |-> cnt == '0);

  assert_late_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    late_flag |=> late_flag);
endmodule

bind pwm_dma_shadow pwm_dma_shadow_chk #(.CH(CH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .period(period), .cnt(cnt), .pwm_out(pwm_out),
  .late_flag(late_flag), .rd_req(rd_req), .rd_rvalid(rd_rvalid), .load(load)
);

// File: tb/pwm_dma_shadow_test.sv
module pwm_dma_shadow_test;
  localparam int CLK_PERIOD = 10;
  localparam int CH = 12;
  localparam int CW = 16;
  localparam int AW = 32;
  localparam int WORDS = CH / 2;
  localparam int P = 24;
  localparam int NPER = 24;
  localparam logic [AW-1:0] BASE = 32'h0000_1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_req;
  logic [AW-1:0] rd_addr;
  logic rd_rvalid = 1'b0;
  logic [2*CW-1:0] rd_rdata = '0;
  logic [CH-1:0] pwm_out;
  logic late_flag;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_dma_shadow #(.CH(CH), .CW(CW), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .base_addr(BASE), .period(CW'(P)),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_rvalid(rd_rvalid),
    .rd_rdata(rd_rdata), .pwm_out(pwm_out), .late_flag(late_flag)
  );

  logic [CH*CW-1:0] exp_q[$];
  string            tag_q[$];
  logic [CH*CW-1:0] fetched = '0;
  logic [CH-1:0]    mism = '0;
  int phase = 0, consumed = 0, exp_idx = 0, req_idx = 0, rc = 0, lat = 2, gen = 0;
  bit full_b = 0, pend = 0, drove = 0, exp_late = 0, load_prev = 1, prev_late = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint a, input longint e);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, a, e);
    end
  endtask

  function automatic logic [CW-1:0] duty_of(int g, int ch);
    if (ch == 2) return CW'(P);
    if (ch == 0 && g % 3 == 1) return '0;
    if (ch == 1 && g % 2 == 0) return 16'hFFFF;
    return CW'((g * 7 + ch * 5 + 3) % (P + 3));
  endfunction

  function automatic logic [2*CW-1:0] word_of(int g, int k);
    return {duty_of(g, 2*k+1), duty_of(g, 2*k)};
  endfunction

  task automatic step();
    logic [2*CW-1:0] w;
    if (drove) begin
      consumed++;
      drove = 0;
      if (consumed == WORDS) full_b = 1;
    end
    chk(late_flag == exp_late, "R7", "late_flag", late_flag, exp_late);
    for (int i = 0; i < CH; i++)
      if (pwm_out[i] != (phase < int'(exp_q[0][i*CW +: CW]))) mism[i] = 1'b1;
    if (phase == P-1) begin
      for (int i = 0; i < CH; i++) begin
        int d = int'(exp_q[0][i*CW +: CW]);
        string rq = (d == 0 || d >= P) ? "R1" : tag_q[0];
        chk(!mism[i], rq, $sformatf("ch%0d duty %0d period shape", i, d), mism[i], 0);
      end
      mism = '0;
    end
    if (phase == 0 && load_prev) begin
      chk(rd_req == 1'b1, "R4", "request after load", rd_req, 1);
      load_prev = 0;
    end
    if (rd_req) begin
      chk(rd_addr == BASE + AW'(4 * exp_idx), "R2", "read address", rd_addr, BASE + AW'(4 * exp_idx));
      pend = 1;
      rc = lat;
      req_idx = exp_idx;
      exp_idx++;
    end
    if (phase == P-1) begin
      if (full_b) begin
        exp_q.push_back(fetched);
        tag_q.push_back(prev_late ? "R6" : "R3");
        full_b = 0;
        consumed = 0;
        exp_idx = 0;
        load_prev = 1;
        prev_late = 0;
      end else begin
        exp_q.push_back(exp_q[$]);
        tag_q.push_back("R5");
        exp_late = 1;
        prev_late = 1;
      end
      gen++;
    end
    rd_rvalid = 1'b0;
    if (pend) begin
      if (rc <= 1) begin
        w = word_of(gen, req_idx);
        rd_rvalid = 1'b1;
        rd_rdata = w;
        fetched[req_idx*2*CW +: 2*CW] = w;
        pend = 0;
        drove = 1;
      end else begin
        rc--;
      end
    end
    if (phase == P-1) begin
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
    end
    phase = (phase == P-1) ? 0 : phase + 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(pwm_out == '0, "R8", "outputs in reset", pwm_out, 0);
    chk(late_flag == 1'b0, "R8", "late_flag in reset", late_flag, 0);
    chk(rd_req == 1'b1, "R8", "request in reset", rd_req, 1);
    chk(rd_addr == BASE, "R8", "address in reset", rd_addr, BASE);
    exp_q.push_back('0);
    tag_q.push_back("R8");
    rst_n = 1'b1;
    for (int cyc = 0; cyc < P * NPER; cyc++) begin
      int per = cyc / P;
      if (cyc > 0) @(negedge clk);
      lat = (per < 6) ? 2 : (per < 10) ? 3 : (per < 14) ? 4 : (per < 20) ? 6 : 1;
      step();
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule